// File: doc/BRIEF.md
# Privileged Jump Target Predictor with Return Stack

This block sits in the fetch path of a processor and handles one privileged jump instruction. It decodes the instruction word and picks a predicted fetch target. A two-bit hint field selects one of four actions on a small circular return-address stack: plain jump, call, return, or coroutine swap. A jump or call predicts a target from the PC plus a scaled, signed longword displacement. A return or coroutine takes the top of the stack as its prediction.

The resolved register value, which is the true target, arrives with the instruction. The block compares it against the prediction with bit 0 masked. When they differ, it asks the front end to kill younger instructions and refetch. Bit 0 of the resolved value becomes the new privileged-mode bit.

An instruction can carry a stall flag. That flag always forces a redirect and holds fetch until a retire-or-abort indication arrives. Every result is registered and appears one clock after the cycle in which the instruction is accepted.

Top module: `pjmp_predictor`

## Requirements
- R1: An instruction is accepted only when `insn_valid_i` is high, `fetch_stall_o` is low and bits [31:26] of `insn_i` equal 6'h1E. Any other opcode leaves `pred_valid_o` low and leaves the stack, `pred_target_o` and `priv_mode_o` unchanged.
- R2: Hint `insn_i[15:14]` = 2'b00 (jump) predicts `insn_pc_i + 4*sext(insn_i[12:0])` and leaves the stack untouched.
- R3: Hint 2'b01 (call) predicts the same target as R2 and pushes `insn_pc_i + 4` onto the stack.
- R4: Hint 2'b10 (return) predicts the top stack entry and pops it.
- R5: Hint 2'b11 (coroutine) predicts the top stack entry and replaces it with `insn_pc_i + 4`, so the stack depth does not change.
- R6: The stack is circular with 8 entries. A push onto a full stack overwrites the oldest entry. A pop from an empty stack returns whatever that slot holds and still moves the pointer back.
- R7: On acceptance, `priv_mode_o` takes bit 0 of `rb_value_i`.
- R8: `redirect_o` is raised with the result when `rb_value_i` with bit 0 cleared differs from the predicted target.
- R9: When stall bit `insn_i[13]` is set, `redirect_o` is forced high and `fetch_stall_o` rises. `fetch_stall_o` stays high until a cycle with `retire_i` high, and it is low from the following clock. Instructions presented while it is high are not accepted.
- R10: After reset the stack pointer and all entries are zero. `pred_valid_o`, `redirect_o`, `fetch_stall_o` and `pred_target_o` are zero, and `priv_mode_o` is 1.
- R11: Results appear on the clock edge that ends the accepting cycle. `pred_valid_o` and `redirect_o` are single-cycle pulses, and `pred_target_o` holds its value between acceptances.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| insn_valid_i | input | 1 | Instruction word is valid this cycle |
| insn_i | input | 32 | Instruction word |
| insn_pc_i | input | PC_W | PC of the instruction |
| rb_value_i | input | PC_W | Resolved target register value; bit 0 is the new mode bit |
| retire_i | input | 1 | Stalling instruction retired or aborted |
| pred_valid_o | output | 1 | One-cycle pulse: prediction result valid |
| pred_target_o | output | PC_W | Predicted fetch target |
| redirect_o | output | 1 | Mispredict: kill younger instructions and refetch the target |
| fetch_stall_o | output | 1 | Hold instruction fetch |
| priv_mode_o | output | 1 | Privileged-mode bit |

## Verification
The embedded assertions check these on every cycle:
- stack pointer motion for each push, pop and swap combination;
- that the written entry becomes the top after a coroutine swap;
- that the stall holds until retire;
- that nothing is accepted while stalled;
- that foreign opcodes produce no result;
- that the mode bit tracks the resolved value.

Target arithmetic with signed displacements, wrap-around overwrite on a full stack, underflow returning stale entries, and redirect on a wrong resolved target can only be shown by the bench's scenarios. The bench compares every cycle against its own behavioural stack model.

// File: rtl/pjmp_pkg.sv
package pjmp_pkg;

   localparam logic [5:0] PJMP_OPCODE = 6'h1E;
   localparam int         INSN_W      = 32;
   localparam int         DISP_W      = 13;

   typedef enum logic [1:0] {
      HINT_JUMP = 2'b00,
      HINT_CALL = 2'b01,
      HINT_RET  = 2'b10,
      HINT_CORO = 2'b11
   } hint_e;

   typedef struct packed {
      logic              match;
      hint_e             hint;
      logic              stall;
      logic [DISP_W-1:0] disp;
   } dec_t;

endpackage

// File: rtl/pjmp_decode.sv
module pjmp_decode
   import pjmp_pkg::*;
#(
   parameter int PC_W = 32
) (
   input  logic [INSN_W-1:0] insn_i,
   input  logic [PC_W-1:0]   pc_i,
   output dec_t              dec_o,
   output logic [PC_W-1:0]   seq_pc_o,
   output logic [PC_W-1:0]   jump_tgt_o
);

   localparam int EXT_W = PC_W - DISP_W - 2;

   if (EXT_W < 1) begin : g_bad_pc_w
      $error("pjmp_decode: PC_W too small for displacement");
   end

   logic [PC_W-1:0] disp_bytes;

   always_comb begin
      dec_o.match = (insn_i[31:26] == PJMP_OPCODE);
      dec_o.hint  = hint_e'(insn_i[15:14]);
      dec_o.stall = insn_i[13];
      dec_o.disp  = insn_i[DISP_W-1:0];
   end

   assign disp_bytes = {{EXT_W{insn_i[DISP_W-1]}}, insn_i[DISP_W-1:0], 2'b00};
   assign seq_pc_o   = pc_i + PC_W'(4);
   assign jump_tgt_o = pc_i + disp_bytes;

endmodule

// File: rtl/pjmp_ras.sv
module pjmp_ras #(
   parameter int DEPTH = 8,
   parameter int W     = 32
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         push_i,
   input  logic         pop_i,
   input  logic [W-1:0] push_data_i,
   output logic [W-1:0] top_o
);

   localparam int PTR_W = $clog2(DEPTH);

   if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
      $error("pjmp_ras: DEPTH must be a power of two, at least 2");
   end

   logic [PTR_W-1:0] ptr_q;
   logic [PTR_W-1:0] ptr_d;
   logic [PTR_W-1:0] wr_idx;
   logic [W-1:0]     slot_q [DEPTH];

   always_comb begin
      ptr_d  = ptr_q;
      wr_idx = ptr_q;
      unique case ({push_i, pop_i})
         2'b10:   begin ptr_d = ptr_q + 1'b1; wr_idx = ptr_q + 1'b1; end
         2'b01:   ptr_d = ptr_q - 1'b1;
         default: ;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ptr_q <= '0;
      else        ptr_q <= ptr_d;
   end

   for (genvar e = 0; e < DEPTH; e++) begin : g_slot
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            slot_q[e] <= '0;
         else if (push_i && wr_idx == PTR_W'(e))
            slot_q[e] <= push_data_i;
      end
   end

   assign top_o = slot_q[ptr_q];

   // R3
   push_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      push_i && !pop_i |=> ptr_q == PTR_W'($past(ptr_q) + 1'b1));
   // R4
   pop_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pop_i && !push_i |=> ptr_q == PTR_W'($past(ptr_q) - 1'b1));
   // R5
   swap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pop_i && push_i |=> $stable(ptr_q) && top_o == $past(push_data_i));
   // R3
   push_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
      push_i |=> top_o == $past(push_data_i));

endmodule

// File: rtl/pjmp_predictor.sv
module pjmp_predictor
   import pjmp_pkg::*;
#(
   parameter int PC_W         = 32,
   parameter int STACK_DEPTH  = 8,
   parameter bit CHECK_TARGET = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              insn_valid_i,
   input  logic [INSN_W-1:0] insn_i,
   input  logic [PC_W-1:0]   insn_pc_i,
   input  logic [PC_W-1:0]   rb_value_i,
   input  logic              retire_i,
   output logic              pred_valid_o,
   output logic [PC_W-1:0]   pred_target_o,
   output logic              redirect_o,
   output logic              fetch_stall_o,
   output logic              priv_mode_o
);

   dec_t            dec;
   logic [PC_W-1:0] seq_pc;
   logic [PC_W-1:0] jump_tgt;
   logic [PC_W-1:0] stack_top;
   logic [PC_W-1:0] pred;
   logic            accept;
   logic            do_push;
   logic            do_pop;
   logic            wrong_tgt;

   pjmp_decode #(.PC_W(PC_W)) u_decode (
      .insn_i     (insn_i),
      .pc_i       (insn_pc_i),
      .dec_o      (dec),
      .seq_pc_o   (seq_pc),
      .jump_tgt_o (jump_tgt)
   );

   assign accept  = insn_valid_i && dec.match && !fetch_stall_o;
   assign do_push = accept && (dec.hint == HINT_CALL || dec.hint == HINT_CORO);
   assign do_pop  = accept && (dec.hint == HINT_RET  || dec.hint == HINT_CORO);

   pjmp_ras #(.DEPTH(STACK_DEPTH), .W(PC_W)) u_ras (
      .clk         (clk),
      .rst_n       (rst_n),
      .push_i      (do_push),
      .pop_i       (do_pop),
      .push_data_i (seq_pc),
      .top_o       (stack_top)
   );

   assign pred = dec.hint[1] ? stack_top : jump_tgt;

   if (CHECK_TARGET) begin : g_tgt_cmp
      assign wrong_tgt = ({rb_value_i[PC_W-1:1], 1'b0} != pred);
   end else begin : g_no_tgt_cmp
      assign wrong_tgt = 1'b0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pred_valid_o  <= 1'b0;
         pred_target_o <= '0;
         redirect_o    <= 1'b0;
         fetch_stall_o <= 1'b0;
         priv_mode_o   <= 1'b1;
      end else begin
         pred_valid_o <= accept;
         redirect_o   <= accept && (dec.stall || wrong_tgt);
         if (accept) begin
            pred_target_o <= pred;
            priv_mode_o   <= rb_value_i[0];
            fetch_stall_o <= dec.stall;
         end else if (retire_i) begin
            fetch_stall_o <= 1'b0;
         end
      end
   end

   // R9
   stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fetch_stall_o && !retire_i |=> fetch_stall_o);
   // R9
   stall_redirect_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(fetch_stall_o) |-> redirect_o && pred_valid_o);
   // R9
   stalled_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fetch_stall_o |=> !pred_valid_o);
   // R11
   redirect_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      redirect_o |-> pred_valid_o);
   // R7
   priv_track_chk: assert property (@(posedge clk) disable iff (!rst_n)
      accept |=> priv_mode_o == $past(rb_value_i[0]));
   // R1
   foreign_opc_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(insn_valid_i && dec.match) |=> !pred_valid_o && $stable(priv_mode_o));

endmodule

// File: tb/pjmp_predictor_tb_top.sv
module pjmp_predictor_tb_top;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        insn_valid_i;
   logic [31:0] insn_i;
   logic [31:0] insn_pc_i;
   logic [31:0] rb_value_i;
   logic        retire_i;
   logic        pred_valid_o;
   logic [31:0] pred_target_o;
   logic        redirect_o;
   logic        fetch_stall_o;
   logic        priv_mode_o;

   always #5 clk = ~clk;

   pjmp_predictor dut_i (
      .clk           (clk),
      .rst_n         (rst_n),
      .insn_valid_i  (insn_valid_i),
      .insn_i        (insn_i),
      .insn_pc_i     (insn_pc_i),
      .rb_value_i    (rb_value_i),
      .retire_i      (retire_i),
      .pred_valid_o  (pred_valid_o),
      .pred_target_o (pred_target_o),
      .redirect_o    (redirect_o),
      .fetch_stall_o (fetch_stall_o),
      .priv_mode_o   (priv_mode_o)
   );

   int n_checks = 0;
   int n_fail   = 0;
   bit done     = 0;

   task automatic check(input bit ok, input string tag, input logic [31:0] act,
                        input logic [31:0] exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
      end
   endtask

   // behavioural reference model
   logic [31:0] m_stk [8];
   int          m_sp;
   logic        m_valid, m_redir, m_stall, m_priv;
   logic [31:0] m_tgt;
   logic [1:0]  m_hint;
   logic        m_acc;
   logic [31:0] m_pred, m_seq, m_jt;
   int          m_d;

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         foreach (m_stk[k]) m_stk[k] = 32'h0;
         m_sp = 0; m_valid = 0; m_redir = 0; m_stall = 0; m_priv = 1;
         m_tgt = 0; m_hint = 0;
      end else begin
         m_acc   = insn_valid_i && !m_stall && insn_i[31:26] == 6'h1E;
         m_valid = 0;
         m_redir = 0;
         if (!m_acc && m_stall && retire_i) m_stall = 0;
         if (m_acc) begin
            m_d    = insn_i[12] ? int'(insn_i[12:0]) - 8192 : int'(insn_i[12:0]);
            m_seq  = insn_pc_i + 32'd4;
            m_jt   = insn_pc_i + 32'(m_d * 4);
            m_hint = insn_i[15:14];
            case (m_hint)
               2'd0: m_pred = m_jt;
               2'd1: begin m_pred = m_jt; m_sp = (m_sp + 1) % 8; m_stk[m_sp] = m_seq; end
               2'd2: begin m_pred = m_stk[m_sp]; m_sp = (m_sp + 7) % 8; end
               default: begin m_pred = m_stk[m_sp]; m_stk[m_sp] = m_seq; end
            endcase
            m_valid = 1;
            m_tgt   = m_pred;
            m_priv  = rb_value_i[0];
            m_stall = insn_i[13];
            m_redir = insn_i[13] || ((rb_value_i & ~32'h1) != m_pred);
         end
      end
   end

   function automatic string tgt_tag(input logic [1:0] h);
      case (h)
         2'd0: return "R2 target";
         2'd1: return "R3 target";
         2'd2: return "R4 R6 target";
         default: return "R5 R6 target";
      endcase
   endfunction

   // per-cycle comparison away from the active edge
   always @(negedge clk) begin
      if (rst_n === 1'b1 && !done) begin
         check(pred_valid_o === m_valid, "R1 R11 valid", 32'(pred_valid_o), 32'(m_valid));
         check(pred_target_o === m_tgt, tgt_tag(m_hint), pred_target_o, m_tgt);
         check(redirect_o === m_redir, "R8 R9 redirect", 32'(redirect_o), 32'(m_redir));
         check(fetch_stall_o === m_stall, "R9 stall", 32'(fetch_stall_o), 32'(m_stall));
         check(priv_mode_o === m_priv, "R7 priv", 32'(priv_mode_o), 32'(m_priv));
      end
   end

   // model's prediction for the next instruction, to build a correct resolved value
   function automatic logic [31:0] next_pred(input logic [1:0] h, input logic [12:0] disp,
                                              input logic [31:0] pc);
      int d;
      d = disp[12] ? int'(disp) - 8192 : int'(disp);
      if (h[1]) return m_stk[m_sp];
      return pc + 32'(d * 4);
   endfunction

   task automatic issue(input logic [5:0] opc, input logic [1:0] h, input logic sb,
                        input logic [12:0] disp, input logic [31:0] pc,
                        input bit wrong, input logic pbit);
      logic [31:0] rb;
      @(negedge clk);
      rb = next_pred(h, disp, pc);
      if (wrong) rb = rb ^ 32'h100;
      insn_valid_i = 1'b1;
      insn_i       = {opc, 5'd31, 5'd7, h, sb, disp};
      insn_pc_i    = pc;
      rb_value_i   = (rb & ~32'h1) | {31'h0, pbit};
      @(negedge clk);
      insn_valid_i = 1'b0;
   endtask

   initial begin
      rst_n = 0; insn_valid_i = 0; insn_i = 0; insn_pc_i = 0; rb_value_i = 0; retire_i = 0;
      repeat (3) @(negedge clk);
      // R10 reset state
      check(pred_valid_o === 0 && redirect_o === 0 && fetch_stall_o === 0,
            "R10 reset outputs", {29'h0, pred_valid_o, redirect_o, fetch_stall_o}, 32'h0);
      check(priv_mode_o === 1, "R10 reset priv", 32'(priv_mode_o), 32'h1);
      check(pred_target_o === 0, "R10 reset target", pred_target_o, 32'h0);
      rst_n = 1;
      // R4 R6: pop on empty stack returns reset slot content
      issue(6'h1E, 2'd2, 0, 13'd0, 32'h1000, 0, 1);
      // R2: jumps with positive and negative displacement
      issue(6'h1E, 2'd0, 0, 13'd25, 32'h2000, 0, 0);
      issue(6'h1E, 2'd0, 0, 13'h1FFF, 32'h2000, 0, 1);
      issue(6'h1E, 2'd0, 0, 13'h1000, 32'h8000_0000, 1, 0);
      // R1: foreign opcode ignored
      issue(6'h1D, 2'd1, 1, 13'd3, 32'h3000, 0, 1);
      // R3 R4: call then return
      issue(6'h1E, 2'd1, 0, 13'd64, 32'h4000, 0, 1);
      issue(6'h1E, 2'd1, 0, 13'd8, 32'h5000, 0, 1);
      issue(6'h1E, 2'd2, 0, 13'd0, 32'h6000, 0, 1);
      // R5: coroutine swap
      issue(6'h1E, 2'd3, 0, 13'd0, 32'h7000, 0, 0);
      issue(6'h1E, 2'd3, 0, 13'd0, 32'h7100, 1, 1);
      issue(6'h1E, 2'd2, 0, 13'd0, 32'h7200, 0, 1);
      // R8: wrong resolved target
      issue(6'h1E, 2'd2, 0, 13'd0, 32'h7300, 1, 1);
      // R6: overflow with nine calls then nine returns
      for (int k = 0; k < 9; k++)
         issue(6'h1E, 2'd1, 0, 13'd4, 32'h1_0000 + 32'(k * 16), 0, 1);
      for (int k = 0; k < 9; k++)
         issue(6'h1E, 2'd2, 0, 13'd0, 32'h2_0000, 0, 1);
      // R9: stall bit, instruction during stall ignored, released by retire
      issue(6'h1E, 2'd0, 1, 13'd2, 32'h9000, 0, 0);
      issue(6'h1E, 2'd1, 0, 13'd2, 32'hA000, 0, 1);
      repeat (2) @(negedge clk);
      retire_i = 1;
      @(negedge clk);
      retire_i = 0;
      issue(6'h1E, 2'd1, 0, 13'd2, 32'hB000, 0, 1);
      // R9: retire and new instruction in the same cycle as stall release
      issue(6'h1E, 2'd3, 1, 13'd0, 32'hC000, 1, 0);
      @(negedge clk);
      retire_i = 1; insn_valid_i = 1; insn_i = {6'h1E, 5'd31, 5'd7, 2'd0, 1'b0, 13'd1};
      @(negedge clk);
      retire_i = 0; insn_valid_i = 0;
      issue(6'h1E, 2'd2, 0, 13'd0, 32'hD000, 0, 1);
      repeat (3) @(negedge clk);
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         done = 1;
         n_checks++;
         n_fail++;
         $display("FAIL watchdog expired actual=%h expected=%h", 32'h1, 32'h0);
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
         $finish;
      end
   end

endmodule